// File: doc/BRIEF.md
# Membrane Grid Time-Step Engine

This block advances a small rectangular membrane, modelled as a grid of nodes, by one discrete time step each time a sample tick arrives. It holds two displacement planes in internal storage, the present one (step n) and the one before it (step n−1), and walks through every node once per tick. Each node's next value comes from a five-point spatial stencil over the present plane plus temporal terms built from the node's own present and previous values and a drive term. Every node has its own four coefficients, and those coefficients are loaded through a simple write port.

Drive enters the grid at two diagonally opposite corners: the top-left node and the bottom-right node. The response is read from the other two corners. Both response values are registered when a step completes, so a sample-rate system can tick the block, wait for the step to end and pick up two output samples. A tick that arrives while a step is still in progress does not start a new step. It is counted as an overrun instead.

All values are signed Q16.16 two's-complement words. The grid size, word width, fraction width and overrun counter width are parameters.

Top module: `membrane_stepper`

## Requirements
- R1: After reset, busy, stepDone, overruns, respA and respB are all zero. Both displacement planes and all coefficients are zero.
- R2: A tick sampled while the block is idle starts a step. busy is high for exactly ROWS*COLS cycles, beginning the cycle after the tick. stepDone pulses high for one cycle in the cycle right after busy falls.
- R3: The next value of node k is floor(s1·ξ/2^16) + floor(p1·u[n]/2^16) + floor(p2·u[n−1]/2^16) + floor(p3·f/2^16). Each product is formed at full precision and floored separately, and the four terms are summed without loss.
- R4: ξ is the sum of the four orthogonal neighbours minus four times the node itself. A neighbour outside the grid reads as zero.
- R5: coefWe writes coefData into the coefficient chosen by coefSel (0 = s1, 1 = p1, 2 = p2, 3 = p3) for the node at coefAddr = row·COLS + col. Each node keeps its own coefficients.
- R6: The drive term f is stimA at node (0,0) and stimB at node (ROWS−1, COLS−1), sampled on the accepting tick. It is zero at every other node. Changing stimA or stimB during a step has no effect on that step.
- R7: When a step ends, respA takes the new value of node (0, COLS−1) and respB takes the new value of node (ROWS−1, 0). Both then hold until the next step ends.
- R8: Nodes are visited in row-major order, one per cycle. Every stencil and temporal operand comes from the planes as they stood when the step began.
- R9: A result above 2^31−1 is clamped to 0x7FFFFFFF. A result below −2^31 is clamped to 0x80000000.
- R10: Each tick sampled while busy adds one to overruns, which saturates at its all-ones value. Such a tick never starts a further step.
- R11: After a step, the newly computed plane becomes the present plane and the former present plane becomes the previous plane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Sample tick; starts a step when idle |
| stimA | input | DW | Drive value for node (0,0), Q16.16 |
| stimB | input | DW | Drive value for node (ROWS−1,COLS−1), Q16.16 |
| coefWe | input | 1 | Coefficient write strobe |
| coefSel | input | 2 | Coefficient select: 0 s1, 1 p1, 2 p2, 3 p3 |
| coefAddr | input | IDXW | Node index row·COLS+col for the write |
| coefData | input | DW | Coefficient value, Q16.16 |
| busy | output | 1 | High while a step is in progress |
| stepDone | output | 1 | One-cycle pulse after a step completes |
| respA | output | DW | Value of node (0,COLS−1) after the last step |
| respB | output | DW | Value of node (ROWS−1,0) after the last step |
| overruns | output | OVW | Saturating count of ticks received while busy |

## Verification
The bench builds the block with a 6-row by 5-column grid. Because the grid is neither square nor a power of two, a swapped row and column, or a wrong boundary test, changes the corner responses within a few steps. The overrun counter is built 3 bits wide, so two steps that each collect four overrun ticks drive it past saturation at 7. A bit-exact model in the bench runs dozens of steps under gentle per-node coefficients and under explosive ones. Those runs reach the ordering rule, the zero boundary, the per-product flooring and the clamp at both signs.

// File: rtl/membrane_pkg.sv
package membrane_pkg;

  // Strobes from the sequencer to the arithmetic side
  typedef struct packed {
    logic start;  // tick accepted: latch the drive values
    logic write;  // compute and store the node at nodeIdx
    logic last;   // final node of the step
  } step_ctl_t;

  typedef enum logic [1:0] {
    COEF_S1 = 2'd0,
    COEF_P1 = 2'd1,
    COEF_P2 = 2'd2,
    COEF_P3 = 2'd3
  } coef_sel_e;

endpackage

// File: rtl/membrane_ctrl.sv
module membrane_ctrl
  import membrane_pkg::*;
#(
  parameter int NODES = 64,
  parameter int OVW   = 8,
  parameter int IDXW  = $clog2(NODES)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            tick,
  output step_ctl_t       ctl,
  output logic [IDXW-1:0] nodeIdx,
  output logic            busy,
  output logic            stepDone,
  output logic [OVW-1:0]  overruns
);

  localparam logic [IDXW-1:0] LAST_IDX = IDXW'(NODES - 1);
  localparam logic [OVW-1:0]  OV_MAX   = {OVW{1'b1}};

  logic running;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running  <= 1'b0;
      nodeIdx  <= '0;
      stepDone <= 1'b0;
      overruns <= '0;
    end else begin
      stepDone <= ctl.last;
      if (!running) begin
        if (tick) begin
          running <= 1'b1;
          nodeIdx <= '0;
        end
      end else begin
        if (nodeIdx == LAST_IDX) begin
          running <= 1'b0;
        end else begin
          nodeIdx <= nodeIdx + 1'b1;
        end
        if (tick && overruns != OV_MAX) begin
          overruns <= overruns + 1'b1;
        end
      end
    end
  end

  always_comb begin
    ctl.start = !running && tick;
    ctl.write = running;
    ctl.last  = running && (nodeIdx == LAST_IDX);
  end

  assign busy = running;

  // R2
  start_index_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(running) |-> nodeIdx == '0);

  // R8
  node_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    (running && nodeIdx != LAST_IDX) |=> (running && nodeIdx == IDXW'($past(nodeIdx) + 1'b1)));

  // R2
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    stepDone |=> !stepDone);

  // R10
  overrun_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    (running && tick && overruns != OV_MAX) |=> overruns == OVW'($past(overruns) + 1'b1));

  // R10
  overrun_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(running && tick) |=> $stable(overruns));

endmodule

// File: rtl/membrane_datapath.sv
module membrane_datapath
  import membrane_pkg::*;
#(
  parameter int ROWS = 8,
  parameter int COLS = 8,
  parameter int DW   = 32,
  parameter int FRAC = 16,
  parameter int NODES = ROWS * COLS,
  parameter int IDXW  = $clog2(NODES)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  step_ctl_t              ctl,
  input  logic [IDXW-1:0]        nodeIdx,
  input  logic signed [DW-1:0]   stimA,
  input  logic signed [DW-1:0]   stimB,
  input  logic                   coefWe,
  input  logic [1:0]             coefSel,
  input  logic [IDXW-1:0]        coefAddr,
  input  logic signed [DW-1:0]   coefData,
  output logic signed [DW-1:0]   respA,
  output logic signed [DW-1:0]   respB
);

  localparam int XW = DW + 4;        // stencil sum width
  localparam int PW = DW + XW;       // product width
  localparam int SW = PW + 2;        // accumulator width
  localparam int RESP_A_IDX = COLS - 1;
  localparam int RESP_B_IDX = (ROWS - 1) * COLS;
  localparam logic signed [SW-1:0] SAT_HI = {{(SW-DW+1){1'b0}}, {(DW-1){1'b1}}};
  localparam logic signed [SW-1:0] SAT_LO = ~SAT_HI;

  logic signed [DW-1:0] plane   [2][NODES];
  logic signed [DW-1:0] coefMem [4][NODES];
  logic                 curBank;
  logic signed [DW-1:0] stimLatA, stimLatB;

  logic signed [DW-1:0] nUp, nDn, nLf, nRt, cVal, pVal, fVal;
  logic signed [XW-1:0] xi;
  logic signed [PW-1:0] tS, tC, tP, tF;
  logic signed [SW-1:0] acc;
  logic signed [DW-1:0] newVal;
  int                   rowI, colI, k;

  always_comb begin
    k    = int'(nodeIdx);
    rowI = k / COLS;
    colI = k % COLS;
    cVal = plane[curBank][nodeIdx];
    pVal = plane[!curBank][nodeIdx];
    nUp  = (rowI > 0)        ? plane[curBank][IDXW'(k - COLS)] : '0;
    nDn  = (rowI < ROWS - 1) ? plane[curBank][IDXW'(k + COLS)] : '0;
    nLf  = (colI > 0)        ? plane[curBank][IDXW'(k - 1)]    : '0;
    nRt  = (colI < COLS - 1) ? plane[curBank][IDXW'(k + 1)]    : '0;
    fVal = (k == 0) ? stimLatA : (k == NODES - 1) ? stimLatB : '0;

    xi = XW'(nUp) + XW'(nDn) + XW'(nLf) + XW'(nRt) - (XW'(cVal) <<< 2);

    tS = (PW'(coefMem[0][nodeIdx]) * PW'(xi))   >>> FRAC;
    tC = (PW'(coefMem[1][nodeIdx]) * PW'(cVal)) >>> FRAC;
    tP = (PW'(coefMem[2][nodeIdx]) * PW'(pVal)) >>> FRAC;
    tF = (PW'(coefMem[3][nodeIdx]) * PW'(fVal)) >>> FRAC;
    acc = SW'(tS) + SW'(tC) + SW'(tP) + SW'(tF);

    if (acc > SAT_HI)      newVal = {1'b0, {(DW-1){1'b1}}};
    else if (acc < SAT_LO) newVal = {1'b1, {(DW-1){1'b0}}};
    else                   newVal = acc[DW-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int b = 0; b < 2; b++)
        for (int i = 0; i < NODES; i++) plane[b][i] <= '0;
      curBank  <= 1'b0;
      stimLatA <= '0;
      stimLatB <= '0;
      respA    <= '0;
      respB    <= '0;
    end else begin
      if (ctl.start) begin
        stimLatA <= stimA;
        stimLatB <= stimB;
      end
      if (ctl.write) plane[!curBank][nodeIdx] <= newVal;
      if (ctl.last) begin
        curBank <= !curBank;
        respA   <= plane[!curBank][RESP_A_IDX];
        respB   <= plane[!curBank][RESP_B_IDX];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < 4; s++)
        for (int i = 0; i < NODES; i++) coefMem[s][i] <= '0;
    end else if (coefWe) begin
      coefMem[coefSel][coefAddr] <= coefData;
    end
  end

  // R11
  bank_swap_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.last |=> curBank != $past(curBank));

  // R6
  stim_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.write |=> ($stable(stimLatA) && $stable(stimLatB)));

  // R7
  resp_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.last |=> ($stable(respA) && $stable(respB)));

endmodule

// File: rtl/membrane_stepper.sv
module membrane_stepper
  import membrane_pkg::*;
#(
  parameter int ROWS = 8,
  parameter int COLS = 8,
  parameter int DW   = 32,
  parameter int FRAC = 16,
  parameter int OVW  = 8,
  localparam int NODES = ROWS * COLS,
  localparam int IDXW  = $clog2(NODES)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 tick,
  input  logic signed [DW-1:0] stimA,
  input  logic signed [DW-1:0] stimB,
  input  logic                 coefWe,
  input  logic [1:0]           coefSel,
  input  logic [IDXW-1:0]      coefAddr,
  input  logic signed [DW-1:0] coefData,
  output logic                 busy,
  output logic                 stepDone,
  output logic signed [DW-1:0] respA,
  output logic signed [DW-1:0] respB,
  output logic [OVW-1:0]       overruns
);

  step_ctl_t       ctl;
  logic [IDXW-1:0] nodeIdx;

  membrane_ctrl #(.NODES(NODES), .OVW(OVW), .IDXW(IDXW)) uCtrl (
    .clk(clk), .rstN(rstN), .tick(tick), .ctl(ctl), .nodeIdx(nodeIdx),
    .busy(busy), .stepDone(stepDone), .overruns(overruns)
  );

  membrane_datapath #(.ROWS(ROWS), .COLS(COLS), .DW(DW), .FRAC(FRAC),
                      .NODES(NODES), .IDXW(IDXW)) uPath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .nodeIdx(nodeIdx),
    .stimA(stimA), .stimB(stimB), .coefWe(coefWe), .coefSel(coefSel),
    .coefAddr(coefAddr), .coefData(coefData), .respA(respA), .respB(respB)
  );

endmodule

// File: tb/sim_membrane_stepper.sv
module sim_membrane_stepper;

  localparam int CLK_PERIOD = 10;
  localparam int ROWS = 6;
  localparam int COLS = 5;
  localparam int N    = ROWS * COLS;
  localparam int IDXW = $clog2(N);
  localparam int OVW  = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tick = 1'b0;
  logic signed [31:0] stimA = '0, stimB = '0, coefData = '0;
  logic coefWe = 1'b0;
  logic [1:0] coefSel = '0;
  logic [IDXW-1:0] coefAddr = '0;
  logic busy, stepDone;
  logic signed [31:0] respA, respB;
  logic [OVW-1:0] overruns;

  int compared = 0;
  int mismatched = 0;
  int expOver = 0;
  logic [31:0] seed = 32'h1234_5678;

  logic signed [31:0] mCur [N];
  logic signed [31:0] mPrv [N];
  logic signed [31:0] mCoef [4][N];

  always #(CLK_PERIOD/2) clk = ~clk;

  membrane_stepper #(.ROWS(ROWS), .COLS(COLS), .OVW(OVW)) u0 (
    .clk(clk), .rstN(rstN), .tick(tick), .stimA(stimA), .stimB(stimB),
    .coefWe(coefWe), .coefSel(coefSel), .coefAddr(coefAddr), .coefData(coefData),
    .busy(busy), .stepDone(stepDone), .respA(respA), .respB(respB), .overruns(overruns)
  );

  task automatic cmp(input string req, input longint act, input longint exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [31:0] nextRand();
    seed = seed * 32'd1664525 + 32'd1013904223;
    return seed;
  endfunction

  // floor(a*b / 2^16) at full precision
  function automatic logic signed [79:0] qmul(input logic signed [79:0] a, input logic signed [79:0] b);
    logic signed [79:0] p;
    p = a * b;
    return p >>> 16;
  endfunction

  function automatic logic signed [31:0] nodeVal(input int idx, input logic signed [31:0] fa,
                                                  input logic signed [31:0] fb);
    int r, c;
    logic signed [79:0] xs, sum, f;
    r = idx / COLS;
    c = idx % COLS;
    xs = -80'sd4 * 80'(mCur[idx]);
    if (r > 0)        xs = xs + 80'(mCur[idx - COLS]);
    if (r < ROWS - 1) xs = xs + 80'(mCur[idx + COLS]);
    if (c > 0)        xs = xs + 80'(mCur[idx - 1]);
    if (c < COLS - 1) xs = xs + 80'(mCur[idx + 1]);
    f = (idx == 0) ? 80'(fa) : (idx == N - 1) ? 80'(fb) : 80'sd0;
    sum = qmul(80'(mCoef[0][idx]), xs) + qmul(80'(mCoef[1][idx]), 80'(mCur[idx]))
        + qmul(80'(mCoef[2][idx]), 80'(mPrv[idx])) + qmul(80'(mCoef[3][idx]), f);
    if (sum > 80'sd2147483647) return 32'sh7FFF_FFFF;
    if (sum < -80'sd2147483648) return 32'sh8000_0000;
    return sum[31:0];
  endfunction

  task automatic modelStep(input logic signed [31:0] fa, input logic signed [31:0] fb);
    logic signed [31:0] nxt [N];
    for (int i = 0; i < N; i++) nxt[i] = nodeVal(i, fa, fb);
    for (int i = 0; i < N; i++) begin
      mPrv[i] = mCur[i];
      mCur[i] = nxt[i];
    end
  endtask

  task automatic loadCoef(input int sel, input int addr, input logic signed [31:0] val);
    @(negedge clk);
    coefWe = 1'b1; coefSel = 2'(sel); coefAddr = IDXW'(addr); coefData = val;
    @(negedge clk);
    coefWe = 1'b0;
    mCoef[sel][addr] = val;
  endtask

  // One step; ovr != 0 also fires ticks while busy and disturbs the drive inputs
  task automatic runStep(input logic signed [31:0] fa, input logic signed [31:0] fb,
                         input bit ovr, input string tag);
    int cnt;
    @(negedge clk);
    tick = 1'b1; stimA = fa; stimB = fb;
    @(negedge clk);
    tick = 1'b0;
    cnt = 0;
    while (busy && cnt < 4 * N) begin
      cnt++;
      if (ovr) begin
        tick = (cnt == 6 || cnt == 7 || cnt == 20 || cnt == N);
        stimA = ~fa; stimB = 32'sh1234_0000;
      end
      @(negedge clk);
    end
    tick = 1'b0;
    if (ovr) expOver = (expOver + 4 > 7) ? 7 : expOver + 4;
    modelStep(fa, fb);
    // R2 busy length and done pulse
    cmp("R2 busy cycles", cnt, N);
    cmp("R2 stepDone pulse", stepDone, 1);
    cmp({tag, " respA R3/R4/R7/R8/R11"}, respA, mCur[COLS - 1]);
    cmp({tag, " respB R3/R4/R7/R8/R11"}, respB, mCur[(ROWS - 1) * COLS]);
    if (mCur[COLS - 1] == 32'sh7FFF_FFFF || mCur[COLS - 1] == 32'sh8000_0000)
      cmp("R9 clamp respA", respA, mCur[COLS - 1]);
    @(negedge clk);
    cmp("R2 stepDone low after pulse", stepDone, 0);
    if (ovr) begin
      cmp("R10 overrun count", overruns, expOver);
      cmp("R10 no extra step", busy, 0);
      @(negedge clk);
      cmp("R10 still idle", busy, 0);
    end
    cmp("R7 respA held", respA, mCur[COLS - 1]);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) begin
      mCur[i] = '0; mPrv[i] = '0;
      for (int s = 0; s < 4; s++) mCoef[s][i] = '0;
    end
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    cmp("R1 busy", busy, 0);
    cmp("R1 stepDone", stepDone, 0);
    cmp("R1 overruns", overruns, 0);
    cmp("R1 respA", respA, 0);
    cmp("R1 respB", respB, 0);
    // R1 zero coefficients give zero output despite drive
    runStep(32'sh0005_0000, -32'sh0003_0000, 1'b0, "R1 zero coef");

    // R5 per-node coefficients, gentle set
    for (int i = 0; i < N; i++) begin
      loadCoef(0, i, 32'sh0000_2000 + 32'(nextRand() & 32'h1FFF));
      loadCoef(1, i, 32'sh0001_C000 + 32'(nextRand() & 32'h3FFF));
      loadCoef(2, i, -(32'sh0000_E000 + 32'(nextRand() & 32'h1FFF)));
      loadCoef(3, i, 32'sh0000_8000 + 32'(nextRand() & 32'h7FFF));
    end
    // R6 impulse then silence, then alternating drive
    runStep(32'sh0004_0000, 32'sh0000_0000, 1'b0, "R6 impulse A");
    for (int s = 0; s < 14; s++) runStep(32'sh0, 32'sh0, 1'b0, "R4 ring");
    runStep(32'sh0000_0000, -32'sh0007_8000, 1'b0, "R6 impulse B");
    for (int s = 0; s < 10; s++)
      runStep(32'(nextRand() & 32'h0003_FFFF) - 32'sh0002_0000,
              32'(nextRand() & 32'h0003_FFFF) - 32'sh0002_0000, 1'b0, "R3 noise");
    // R6 R10 overrun ticks and input changes during a step
    runStep(32'sh0001_1111, 32'sh0002_2222, 1'b1, "R6 latched drive");

    // R9 explosive coefficients, both signs
    for (int i = 0; i < N; i++) begin
      loadCoef(0, i, 32'sh0001_0000);
      loadCoef(1, i, 32'sh7FFF_0000);
      loadCoef(2, i, 32'sh0);
      loadCoef(3, i, 32'sh0001_0000);
    end
    runStep(32'sh7FFF_FFFF, 32'sh8000_0000, 1'b0, "R9 drive");
    for (int s = 0; s < 8; s++) runStep(32'sh0, 32'sh0, 1'b0, "R9 saturate");
    // R10 second overrun burst saturates the 3-bit counter at 7
    runStep(32'sh0, 32'sh0, 1'b1, "R10 burst");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule